// File: doc/BRIEF.md
# Hybrid DRAM/PCM Row-Buffer Controller

This block is the front end of a memory controller for a main memory made of two parts: a DRAM region and a phase-change (PCM) region. Each region has its own command and fill channel. A small buffer of whole rows is shared by both regions. A read is first looked up in the buffer and, on a hit, is served without touching either bank. On a miss, the block picks a victim entry. It writes that entry back only when it holds a modified DRAM row, and drops it when it holds a PCM row. It then activates the wanted row into the freed entry and returns the requested word from it.

Writes to DRAM are kept in the buffer and reach the bank later as a write-back. Writes to PCM go straight to the PCM channel as a single-word command. If the PCM row is also buffered, the buffered copy is patched as well, so later reads stay coherent.

Requests and responses use valid/ready. Only one request is in flight at a time. `req_ready` is high only while the block is idle. A response is offered with `rsp_valid` and stays unchanged until the consumer raises `rsp_ready`, so the consumer may stall it for any number of cycles. The memory channels are plain pulses: a command is valid for exactly one cycle, and a fill answer is a one-cycle `*_fill_valid` strobe carrying the whole row.

Top module: `hybrid_rowbuf_ctrl`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when no request is in progress and no response is waiting, so at most one request is outstanding.
- R2: Only reads produce a response. Once `rsp_valid` rises, it and `rsp_data` hold unchanged until a cycle with `rsp_ready` high, after which `rsp_valid` falls.
- R3: The request address is `{region, row, column}`. The top bit selects DRAM (0) or PCM (1), the next ROW_AW bits are the row index, and the low COL_AW bits select a DATA_W-bit word in the row. Word c of a row occupies bits `[c*DATA_W +: DATA_W]`.
- R4: A read whose region and row are buffered returns the buffered word two clock edges after acceptance, with no command on either channel.
- R5: On a read miss, one activate command is issued on the addressed region's channel (`cmd_write`=0, the row index, column 0, data 0). The returned row is stored in the chosen entry and the addressed word of it is returned. No two valid entries ever hold the same region and row.
- R6: The victim is the lowest-numbered invalid entry if one exists. Otherwise a round-robin pointer is used, which starts at entry 0 after reset and moves on by one (wrapping) each time a valid entry is replaced.
- R7: Before the activate, a valid victim that holds a modified DRAM row is written back on the DRAM channel (`cmd_write`=1, its row, column 0, data = the full buffered row). A clean DRAM victim or a PCM victim produces no write-back.
- R8: A DRAM write that hits updates the buffered word and marks the entry modified, with no channel command. A DRAM write that misses fetches the row as in R5 (with R6/R7 victim handling), merges the word and marks it modified. Written data is returned by later reads.
- R9: A PCM write issues one PCM command (`cmd_write`=1, row, column, data in the low DATA_W bits) and never allocates an entry. If the row is buffered, the buffered word is updated and the entry stays unmodified.
- R10: After reset all entries are invalid, `req_ready` is high, and `rsp_valid` and both `cmd_valid` outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | {region, row, column} |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | Read data offered |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | DATA_W | Read word |
| dram_cmd_valid | output | 1 | One-cycle DRAM command strobe |
| dram_cmd_write | output | 1 | 1 = row write-back, 0 = activate |
| dram_cmd_row | output | ROW_AW | DRAM row index |
| dram_cmd_col | output | COL_AW | Column (0 for DRAM commands) |
| dram_cmd_data | output | ROW_W | Row written back |
| dram_fill_valid | input | 1 | DRAM activate answer strobe |
| dram_fill_data | input | ROW_W | Activated DRAM row |
| pcm_cmd_valid | output | 1 | One-cycle PCM command strobe |
| pcm_cmd_write | output | 1 | 1 = word write, 0 = activate |
| pcm_cmd_row | output | ROW_AW | PCM row index |
| pcm_cmd_col | output | COL_AW | Word column for writes |
| pcm_cmd_data | output | ROW_W | Write word in the low DATA_W bits |
| pcm_fill_valid | input | 1 | PCM activate answer strobe |
| pcm_fill_data | input | ROW_W | Activated PCM row |

## Verification
The assertions assume the memories are well behaved. A fill strobe arrives only on the channel that received the last activate, only once, and only while the block is waiting for it. The consumer may hold `rsp_ready` low for any length of time. The bench's memory models answer each activate exactly once, a fixed three cycles later, and ignore write commands apart from storing them. The request driver raises `req_valid` only with a fully formed request and drops it right after the accepting edge, which keeps the single-outstanding rule.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } hrb_state_t;
endpackage

// File: rtl/hrb_tag_match.sv
module hrb_tag_match #(
  parameter int ENTRIES = 4,
  parameter int ROW_AW  = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ENTRIES-1:0]        valid_i,
  input  logic [ENTRIES-1:0]        src_i,
  input  logic [ENTRIES*ROW_AW-1:0] row_i,
  input  logic                      look_src_i,
  input  logic [ROW_AW-1:0]         look_row_i,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          hit_idx_o
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (src_i[g] == look_src_i) &&
                      (row_i[g*ROW_AW +: ROW_AW] == look_row_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match;

  AST_UNIQUE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R5
endmodule

// File: rtl/hrb_victim_pick.sv
module hrb_victim_pick #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               advance_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic [IDX_W-1:0] rr_q;
  logic             free_found;

  always_comb begin
    victim_o   = rr_q;
    free_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!free_found && !valid_i[i]) begin
        victim_o   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (advance_i) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  AST_RR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i |-> (&valid_i)); // R6
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&valid_i)) |-> !valid_i[victim_o]); // R6
endmodule

// File: rtl/hybrid_rowbuf_ctrl.sv
module hybrid_rowbuf_ctrl #(
  parameter int DATA_W  = 16,
  parameter int COL_AW  = 2,
  parameter int ROW_AW  = 6,
  parameter int ENTRIES = 4,
  localparam int WORDS  = 1 << COL_AW,
  localparam int ROW_W  = DATA_W * WORDS,
  localparam int ADDR_W = 1 + ROW_AW + COL_AW,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              dram_cmd_valid,
  output logic              dram_cmd_write,
  output logic [ROW_AW-1:0] dram_cmd_row,
  output logic [COL_AW-1:0] dram_cmd_col,
  output logic [ROW_W-1:0]  dram_cmd_data,
  input  logic              dram_fill_valid,
  input  logic [ROW_W-1:0]  dram_fill_data,
  output logic              pcm_cmd_valid,
  output logic              pcm_cmd_write,
  output logic [ROW_AW-1:0] pcm_cmd_row,
  output logic [COL_AW-1:0] pcm_cmd_col,
  output logic [ROW_W-1:0]  pcm_cmd_data,
  input  logic              pcm_fill_valid,
  input  logic [ROW_W-1:0]  pcm_fill_data
);
  import hrb_pkg::*;

  hrb_state_t state;

  logic              cur_write, cur_src;
  logic [ROW_AW-1:0] cur_row;
  logic [COL_AW-1:0] cur_col;
  logic [DATA_W-1:0] cur_wdata;

  logic [ENTRIES-1:0] e_valid, e_src, e_dirty;
  logic [ROW_AW-1:0]  e_row  [ENTRIES];
  logic [ROW_W-1:0]   e_data [ENTRIES];

  logic [ENTRIES*ROW_AW-1:0] row_flat;
  logic                      hit, advance, need_wb, pcm_store, fill_ok;
  logic [IDX_W-1:0]          hit_idx, victim, vic_idx;
  logic [ROW_W-1:0]          fill_row, merged;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign row_flat[g*ROW_AW +: ROW_AW] = e_row[g];
  end

  hrb_tag_match #(.ENTRIES(ENTRIES), .ROW_AW(ROW_AW)) u_match (
    .clk(clk), .rst_n(rst_n),
    .valid_i(e_valid), .src_i(e_src), .row_i(row_flat),
    .look_src_i(cur_src), .look_row_i(cur_row),
    .hit_o(hit), .hit_idx_o(hit_idx)
  );

  hrb_victim_pick #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .valid_i(e_valid), .advance_i(advance), .victim_o(victim)
  );

  assign req_ready = (state == ST_IDLE);
  assign pcm_store = cur_write && cur_src;
  assign advance   = (state == ST_CHECK) && !pcm_store && !hit && e_valid[victim];
  assign need_wb   = e_valid[victim] && !e_src[victim] && e_dirty[victim];
  assign fill_ok   = cur_src ? pcm_fill_valid : dram_fill_valid;
  assign fill_row  = cur_src ? pcm_fill_data : dram_fill_data;

  always_comb begin
    merged = fill_row;
    if (cur_write) merged[int'(cur_col)*DATA_W +: DATA_W] = cur_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      e_valid        <= '0;
      e_src          <= '0;
      e_dirty        <= '0;
      cur_write      <= 1'b0;
      cur_src        <= 1'b0;
      cur_row        <= '0;
      cur_col        <= '0;
      cur_wdata      <= '0;
      vic_idx        <= '0;
      rsp_valid      <= 1'b0;
      rsp_data       <= '0;
      dram_cmd_valid <= 1'b0;
      dram_cmd_write <= 1'b0;
      dram_cmd_row   <= '0;
      dram_cmd_col   <= '0;
      dram_cmd_data  <= '0;
      pcm_cmd_valid  <= 1'b0;
      pcm_cmd_write  <= 1'b0;
      pcm_cmd_row    <= '0;
      pcm_cmd_col    <= '0;
      pcm_cmd_data   <= '0;
    end else begin
      dram_cmd_valid <= 1'b0;
      pcm_cmd_valid  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_write <= req_write;
            cur_src   <= req_addr[ADDR_W-1];
            cur_row   <= req_addr[COL_AW +: ROW_AW];
            cur_col   <= req_addr[COL_AW-1:0];
            cur_wdata <= req_wdata;
            state     <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (pcm_store) begin
            pcm_cmd_valid <= 1'b1;
            pcm_cmd_write <= 1'b1;
            pcm_cmd_row   <= cur_row;
            pcm_cmd_col   <= cur_col;
            pcm_cmd_data  <= ROW_W'(cur_wdata);
            if (hit) e_data[hit_idx][int'(cur_col)*DATA_W +: DATA_W] <= cur_wdata;
            state <= ST_IDLE;
          end else if (hit) begin
            if (cur_write) begin
              e_data[hit_idx][int'(cur_col)*DATA_W +: DATA_W] <= cur_wdata;
              e_dirty[hit_idx] <= 1'b1;
              state <= ST_IDLE;
            end else begin
              rsp_valid <= 1'b1;
              rsp_data  <= e_data[hit_idx][int'(cur_col)*DATA_W +: DATA_W];
              state     <= ST_RESP;
            end
          end else begin
            vic_idx <= victim;
            if (need_wb) begin
              dram_cmd_valid <= 1'b1;
              dram_cmd_write <= 1'b1;
              dram_cmd_row   <= e_row[victim];
              dram_cmd_col   <= '0;
              dram_cmd_data  <= e_data[victim];
            end
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (cur_src) begin
            pcm_cmd_valid <= 1'b1;
            pcm_cmd_write <= 1'b0;
            pcm_cmd_row   <= cur_row;
            pcm_cmd_col   <= '0;
            pcm_cmd_data  <= '0;
          end else begin
            dram_cmd_valid <= 1'b1;
            dram_cmd_write <= 1'b0;
            dram_cmd_row   <= cur_row;
            dram_cmd_col   <= '0;
            dram_cmd_data  <= '0;
          end
          e_valid[vic_idx] <= 1'b0;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (fill_ok) begin
            e_valid[vic_idx] <= 1'b1;
            e_src[vic_idx]   <= cur_src;
            e_dirty[vic_idx] <= cur_write;
            e_row[vic_idx]   <= cur_row;
            e_data[vic_idx]  <= merged;
            if (cur_write) begin
              state <= ST_IDLE;
            end else begin
              rsp_valid <= 1'b1;
              rsp_data  <= fill_row[int'(cur_col)*DATA_W +: DATA_W];
              state     <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R2
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK && hit && !pcm_store) |=> (!dram_cmd_valid && !pcm_cmd_valid)); // R4
  AST_WB_DIRTY_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cmd_valid && dram_cmd_write) |-> (!e_src[vic_idx] && e_dirty[vic_idx])); // R7
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dram_cmd_valid && pcm_cmd_valid)); // R5
endmodule

// File: tb/hybrid_rowbuf_ctrl_test.sv
`timescale 1ns/1ps
module hybrid_rowbuf_ctrl_test;
  localparam int DW = 16, CW = 2, RW = 6, NE = 4, ROWW = 64, AW = 9, LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic dram_cmd_valid, dram_cmd_write, pcm_cmd_valid, pcm_cmd_write;
  logic [RW-1:0] dram_cmd_row, pcm_cmd_row;
  logic [CW-1:0] dram_cmd_col, pcm_cmd_col;
  logic [ROWW-1:0] dram_cmd_data, pcm_cmd_data;
  logic dram_fill_valid = 1'b0, pcm_fill_valid = 1'b0;
  logic [ROWW-1:0] dram_fill_data = '0, pcm_fill_data = '0;

  always #4 clk = ~clk;

  hybrid_rowbuf_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .dram_cmd_valid(dram_cmd_valid), .dram_cmd_write(dram_cmd_write),
    .dram_cmd_row(dram_cmd_row), .dram_cmd_col(dram_cmd_col), .dram_cmd_data(dram_cmd_data),
    .dram_fill_valid(dram_fill_valid), .dram_fill_data(dram_fill_data),
    .pcm_cmd_valid(pcm_cmd_valid), .pcm_cmd_write(pcm_cmd_write),
    .pcm_cmd_row(pcm_cmd_row), .pcm_cmd_col(pcm_cmd_col), .pcm_cmd_data(pcm_cmd_data),
    .pcm_fill_valid(pcm_fill_valid), .pcm_fill_data(pcm_fill_data)
  );

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [ROWW-1:0] act, input logic [ROWW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // golden program view of memory, and memory models behind the channels
  logic [DW-1:0]   gold  [2][64][4];
  logic [ROWW-1:0] mem_d [64];
  logic [ROWW-1:0] mem_p [64];

  function automatic logic [DW-1:0] seed_word(int s, int r, int c);
    return DW'((s * 4001 + r * 263 + c * 37 + 11) * 5);
  endfunction

  function automatic logic [ROWW-1:0] grow(int s, int r);
    return {gold[s][r][3], gold[s][r][2], gold[s][r][1], gold[s][r][0]};
  endfunction

  // reference buffer state
  bit rv[NE], rs[NE], rdty[NE];
  int rrw[NE];
  int rrp = 0;

  typedef struct {
    bit ch;
    bit wr;
    int row;
    int col;
    logic [ROWW-1:0] data;
  } exp_t;
  exp_t exp_q[$];

  int dcnt = 0, pcnt = 0, drow = 0, prow = 0;

  // memory models and per-clock command comparison
  always @(negedge clk) begin
    cycles++;
    dram_fill_valid = 1'b0;
    pcm_fill_valid  = 1'b0;
    if (dcnt > 0) begin
      dcnt--;
      if (dcnt == 0) begin dram_fill_valid = 1'b1; dram_fill_data = mem_d[drow]; end
    end
    if (pcnt > 0) begin
      pcnt--;
      if (pcnt == 0) begin pcm_fill_valid = 1'b1; pcm_fill_data = mem_p[prow]; end
    end
    if (rst_n) begin
      if (dram_cmd_valid && pcm_cmd_valid)
        chk(1'b0, "R5", "two channels at once", 1, 0);
      for (int ch = 0; ch < 2; ch++) begin
        logic v, w;
        int r, c;
        logic [ROWW-1:0] d;
        v = ch ? pcm_cmd_valid : dram_cmd_valid;
        w = ch ? pcm_cmd_write : dram_cmd_write;
        r = ch ? int'(pcm_cmd_row) : int'(dram_cmd_row);
        c = ch ? int'(pcm_cmd_col) : int'(dram_cmd_col);
        d = ch ? pcm_cmd_data : dram_cmd_data;
        if (v) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected channel command", {ch[0], w, r[5:0]}, 0);
          end else begin
            exp_t e;
            string tg;
            e = exp_q.pop_front();
            tg = !e.wr ? "R5" : (e.ch ? "R9" : "R7");
            chk(e.ch == ch[0], tg, "channel", ch, e.ch);
            chk(e.wr == w && e.row == r && e.col == c, tg, "kind/row/col",
                {w, r[5:0], c[1:0]}, {e.wr, e.row[5:0], e.col[1:0]});
            chk(e.data == d, tg, "command data", d, e.data);
          end
          if (ch == 0) begin
            if (w) mem_d[r] = d; else begin dcnt = LAT; drow = r; end
          end else begin
            if (w) mem_p[r][c*DW +: DW] = d[DW-1:0]; else begin pcnt = LAT; prow = r; end
          end
        end
      end
    end
    if (cycles > 100000) begin
      chk(1'b0, "R1", "watchdog expired", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_req(input bit wr, input bit s, input int r, input int c,
                        input logic [DW-1:0] wd, input int hold, input string tag);
    int hi, vi, cnt;
    bit is_hit;
    logic [DW-1:0] expw, d0;
    hi = -1;
    expw = '0;
    for (int i = 0; i < NE; i++)
      if (rv[i] && rs[i] == s && rrw[i] == r) hi = i;
    is_hit = (hi >= 0);
    if (wr && s) begin
      exp_q.push_back('{1'b1, 1'b1, r, c, ROWW'(wd)});
      gold[s][r][c] = wd;
    end else if (is_hit) begin
      if (wr) begin gold[s][r][c] = wd; rdty[hi] = 1'b1; end
      else expw = gold[s][r][c];
    end else begin
      vi = -1;
      for (int i = 0; i < NE; i++) if (vi < 0 && !rv[i]) vi = i;
      if (vi < 0) begin vi = rrp; rrp = (rrp + 1) % NE; end
      if (rv[vi] && !rs[vi] && rdty[vi])
        exp_q.push_back('{1'b0, 1'b1, rrw[vi], 0, grow(0, rrw[vi])});
      exp_q.push_back('{s, 1'b0, r, 0, '0});
      rv[vi] = 1'b1; rs[vi] = s; rrw[vi] = r; rdty[vi] = wr;
      if (wr) gold[s][r][c] = wd; else expw = gold[s][r][c];
    end

    @(negedge clk);
    req_write = wr;
    req_addr  = {s, 6'(r), 2'(c)};
    req_wdata = wd;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1", "ready low while busy", req_ready, 0);
    if (wr) begin
      while (!req_ready) @(negedge clk);
      chk(!rsp_valid, "R2", "no response for a write", rsp_valid, 0);
      @(negedge clk);
      chk(exp_q.size() == 0, s ? "R9" : "R8", "commands outstanding", exp_q.size(), 0);
    end else begin
      cnt = 1;
      while (!rsp_valid) begin @(negedge clk); cnt++; end
      if (is_hit) chk(cnt == 2, "R4", "hit latency", cnt, 2);
      d0 = rsp_data;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_data == d0, "R2", "held response", rsp_data, d0);
      end
      chk(rsp_data == expw, tag, "read data", rsp_data, expw);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(!rsp_valid, "R2", "valid drops after handshake", rsp_valid, 0);
      @(negedge clk);
      chk(exp_q.size() == 0, is_hit ? "R4" : "R5", "commands outstanding", exp_q.size(), 0);
    end
  endtask

  initial begin
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 64; r++)
        for (int c = 0; c < 4; c++) gold[s][r][c] = seed_word(s, r, c);
    for (int r = 0; r < 64; r++) begin
      mem_d[r] = grow(0, r);
      mem_p[r] = grow(1, r);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(req_ready && !rsp_valid && !dram_cmd_valid && !pcm_cmd_valid, "R10", "reset outputs",
        {req_ready, rsp_valid, dram_cmd_valid, pcm_cmd_valid}, 4'b1000);

    do_req(0, 0, 1, 2, 0, 0, "R5");        // DRAM read miss -> entry 0
    do_req(0, 0, 1, 3, 0, 2, "R4");        // hit with back-pressure
    do_req(1, 0, 1, 0, 16'hBEEF, 0, "R8"); // DRAM write hit, entry modified
    do_req(0, 0, 1, 0, 0, 0, "R8");        // read back written word
    do_req(1, 1, 5, 1, 16'h1234, 0, "R9"); // PCM write miss, no allocation
    do_req(0, 1, 5, 1, 0, 1, "R9");        // PCM read miss sees the write -> entry 1
    do_req(1, 1, 5, 1, 16'h5678, 0, "R9"); // PCM write hit patches buffer
    do_req(0, 1, 5, 1, 0, 0, "R9");        // hit returns patched word
    do_req(0, 0, 5, 1, 0, 0, "R3");        // same row index, DRAM region -> entry 2
    do_req(0, 0, 3, 0, 0, 0, "R6");        // entry 3, buffer now full
    do_req(0, 0, 4, 2, 0, 0, "R7");        // victim entry 0: modified DRAM -> write-back
    do_req(0, 1, 6, 0, 0, 0, "R7");        // victim entry 1: PCM -> dropped
    do_req(0, 0, 1, 0, 0, 0, "R8");        // refetch sees written-back word
    do_req(1, 0, 7, 3, 16'hA5A5, 0, "R8"); // DRAM write miss allocates modified
    do_req(0, 0, 7, 3, 0, 0, "R8");

    for (int n = 0; n < 300; n++) begin
      bit wr, s;
      wr = ($urandom % 3) == 0;
      s  = 1'($urandom % 2);
      do_req(wr, s, int'($urandom % 6), int'($urandom % 4), 16'($urandom),
             int'($urandom % 3), "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule